// File: doc/BRIEF.md
# Configurable Interrupt and Overflow Logic

This block gathers three condition signals from a converter (a clock error, an overflow and an underflow) into one status byte. It also drives a single interrupt pin and a separate overflow pin. Each raw condition first crosses a two-flop synchronizer. It then feeds a per-source status cell, which either latches on a chosen edge or follows the level of the condition. The control port reads the status byte and pulses a strobe when it does. That strobe clears any latched edge events.

The interrupt pin asserts when any status bit is set and its enable bit is 1. It has two pin styles. In push-pull mode it is active high. In open-drain mode it is active low and never drives high, so several devices can share one wired-OR line. The overflow pin is always open-drain and active low. It shows overflow OR underflow from the synchronized conditions and ignores the enable bits.

All pins are plain control and status signals, so there is no valid/ready stream and no back-pressure. The register storage and the serial control interface sit outside this block. They present the enable, mode and polarity fields as plain inputs.

Top module: `irq_ovfl_ctrl`

## Requirements
- R1: In `status_reg`, bit 3 is the clock-error source, bit 1 is overflow and bit 0 is underflow. Bits 7:4 and bit 2 always read 0.
- R2: A raw condition reaches the overflow pin two clock edges after it is sampled. It reaches the status byte three clock edges after it is sampled.
- R3: A source takes part in the interrupt only when its enable bit is 1. Enable bits are ordered {clock error, overflow, underflow}. With all enable bits at 0, the interrupt pin stays inactive.
- R4: The trigger mode of a source is {msb, lsb} taken from `mode_msb` and `mode_lsb`, which use the same ordering as the enable bits. 00 is rising edge, 01 is falling edge, and 10 or 11 is level.
- R5: In an edge mode, a status bit is set by the selected edge. It stays set until a clock edge on which `status_rd` is 1, and it clears there. When a new edge and a read arrive on the same clock edge, the bit stays set.
- R6: In level mode, a status bit follows the synchronized condition, and `status_rd` has no effect on it.
- R7: When `active_high` is 1, `irq_oe` is 1 and `irq_out` equals the pending state.
- R8: When `active_high` is 0, `irq_out` is 0, and `irq_oe` is 1 exactly when an interrupt is pending. The pin is never driven high.
- R9: `ovf_pull_low` is 1 whenever the synchronized overflow or underflow condition is 1, whatever the enable bits are.
- R10: While `rst_n` is low, the status byte is 0, no interrupt is pending and the overflow pin is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| raw_clk_err | input | 1 | Raw clock-error condition |
| raw_ovf | input | 1 | Raw overflow condition |
| raw_udf | input | 1 | Raw underflow condition |
| src_en | input | 3 | Enable bits {clock error, overflow, underflow} |
| mode_msb | input | 3 | Trigger mode MSB per source, same ordering |
| mode_lsb | input | 3 | Trigger mode LSB per source, same ordering |
| active_high | input | 1 | 1 = push-pull active high, 0 = open-drain active low |
| status_rd | input | 1 | Strobe from the control port when it reads the status byte |
| status_reg | output | 8 | Status byte |
| irq_out | output | 1 | Interrupt pin data |
| irq_oe | output | 1 | Interrupt pin output enable |
| ovf_pull_low | output | 1 | 1 = overflow pin pulled low |

## Verification
The assertions check these properties on every cycle:
- the reserved status bits read 0;
- the pin-style rules of the interrupt hold, including that open-drain mode never drives high;
- the interrupt stays quiet when every enable bit is 0;
- a latched edge bit holds until a read;
- the overflow pin tracks the raw inputs two edges later;
- the status byte is clear while reset is held.

Other behaviour only shows in the bench's scenarios, which compare every cycle against the reference model:
- that the falling-edge mode ignores rising edges;
- that a read on the same edge as a new event leaves the bit set;
- that level mode ignores the read strobe;
- the exact three-edge latency into the status byte.

// File: rtl/irq_pkg.sv
package irq_pkg;

  localparam int STATUS_W = 8;
  localparam int NUM_SRC  = 3;

  // Source indices within the per-source vectors
  localparam int SRC_UDF = 0;
  localparam int SRC_OVF = 1;
  localparam int SRC_CLK = 2;

  // Status byte bit position of each source (decoded by software)
  localparam int SRC_POS [NUM_SRC] = '{0, 1, 3};

  typedef enum logic [1:0] {
    TRIG_RISE   = 2'b00,
    TRIG_FALL   = 2'b01,
    TRIG_LEVEL  = 2'b10,
    TRIG_LEVEL2 = 2'b11
  } trig_mode_e;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell
  import irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cond,
  input  trig_mode_e mode,
  input  logic       rd_clr,
  output logic       flag
);

  logic prev;
  logic edge_hit;
  logic level_mode;

  always_comb begin
    edge_hit   = 1'b0;
    level_mode = 1'b0;
    unique case (mode)
      TRIG_RISE: edge_hit = cond & ~prev;
      TRIG_FALL: edge_hit = ~cond & prev;
      default:   level_mode = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= 1'b0;
      flag <= 1'b0;
    end else begin
      prev <= cond;
      if (level_mode)   flag <= cond;
      else if (edge_hit) flag <= 1'b1;   // new event beats a read
      else if (rd_clr)   flag <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive (
  input  logic pending,
  input  logic active_high,
  output logic pin_data,
  output logic pin_oe
);

  always_comb begin
    if (active_high) begin
      pin_data = pending;
      pin_oe   = 1'b1;
    end else begin
      pin_data = 1'b0;     // open-drain: only ever pulls low
      pin_oe   = pending;
    end
  end

endmodule

// File: rtl/irq_ovfl_ctrl.sv
module irq_ovfl_ctrl
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                raw_clk_err,
  input  logic                raw_ovf,
  input  logic                raw_udf,
  input  logic [NUM_SRC-1:0]  src_en,
  input  logic [NUM_SRC-1:0]  mode_msb,
  input  logic [NUM_SRC-1:0]  mode_lsb,
  input  logic                active_high,
  input  logic                status_rd,
  output logic [STATUS_W-1:0] status_reg,
  output logic                irq_out,
  output logic                irq_oe,
  output logic                ovf_pull_low
);

  logic [NUM_SRC-1:0] raw_vec;
  logic [NUM_SRC-1:0] sync_vec;
  logic [NUM_SRC-1:0] src_flag;
  logic               pending;

  always_comb begin
    raw_vec          = '0;
    raw_vec[SRC_UDF] = raw_udf;
    raw_vec[SRC_OVF] = raw_ovf;
    raw_vec[SRC_CLK] = raw_clk_err;
  end

  irq_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_vec),
    .q     (sync_vec)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    trig_mode_e mode_i;
    assign mode_i = trig_mode_e'({mode_msb[i], mode_lsb[i]});

    irq_src_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .cond   (sync_vec[i]),
      .mode   (mode_i),
      .rd_clr (status_rd),
      .flag   (src_flag[i])
    );
  end

  always_comb begin
    status_reg = '0;
    for (int i = 0; i < NUM_SRC; i++) status_reg[SRC_POS[i]] = src_flag[i];
  end

  assign pending = |(src_flag & src_en);

  irq_pin_drive u_drv (
    .pending     (pending),
    .active_high (active_high),
    .pin_data    (irq_out),
    .pin_oe      (irq_oe)
  );

  assign ovf_pull_low = sync_vec[SRC_OVF] | sync_vec[SRC_UDF];

endmodule

// File: rtl/irq_ovfl_ctrl_chk.sv
module irq_ovfl_ctrl_chk
  import irq_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                raw_ovf,
  input logic                raw_udf,
  input logic [NUM_SRC-1:0]  src_en,
  input logic [NUM_SRC-1:0]  mode_msb,
  input logic                active_high,
  input logic                status_rd,
  input logic [STATUS_W-1:0] status_reg,
  input logic                irq_out,
  input logic                irq_oe,
  input logic                ovf_pull_low
);

  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status_reg & 8'hF4) == 8'h00);

  a_r3_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (src_en == '0) |-> (active_high ? !irq_out : !irq_oe));

  a_r5_edge_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (status_reg[1] && !status_rd && !mode_msb[SRC_OVF]) |=> status_reg[1]);

  a_r7_push_pull_drives: assert property (@(posedge clk) disable iff (!rst_n)
    active_high |-> irq_oe);

  a_r8_never_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
    !active_high |-> !irq_out);

  a_r9_ovf_tracks_raw: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> (ovf_pull_low == $past(raw_ovf | raw_udf, 2)));

  a_r10_reset_clear: assert property (@(posedge clk)
    !rst_n |-> (status_reg == 8'h00 && !ovf_pull_low));

endmodule

bind irq_ovfl_ctrl irq_ovfl_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .raw_ovf      (raw_ovf),
  .raw_udf      (raw_udf),
  .src_en       (src_en),
  .mode_msb     (mode_msb),
  .active_high  (active_high),
  .status_rd    (status_rd),
  .status_reg   (status_reg),
  .irq_out      (irq_out),
  .irq_oe       (irq_oe),
  .ovf_pull_low (ovf_pull_low)
);

// File: tb/tb_irq_ovfl_ctrl.sv
module tb_irq_ovfl_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       raw_clk_err = 1'b0, raw_ovf = 1'b0, raw_udf = 1'b0;
  logic [2:0] src_en = '0, mode_msb = '0, mode_lsb = '0;
  logic       active_high = 1'b0, status_rd = 1'b0;
  logic [7:0] status_reg;
  logic       irq_out, irq_oe, ovf_pull_low;

  int    n_vec = 0, n_bad = 0;
  string ph = "R10";

  always #2.5 clk = ~clk;   // 200 MHz

  irq_ovfl_ctrl dut (
    .clk(clk), .rst_n(rst_n), .raw_clk_err(raw_clk_err), .raw_ovf(raw_ovf),
    .raw_udf(raw_udf), .src_en(src_en), .mode_msb(mode_msb), .mode_lsb(mode_lsb),
    .active_high(active_high), .status_rd(status_rd), .status_reg(status_reg),
    .irq_out(irq_out), .irq_oe(irq_oe), .ovf_pull_low(ovf_pull_low)
  );

  // Reference model: history of raw samples {clk_err, ovf, udf}
  logic [2:0] hq [$] = '{3'b0, 3'b0, 3'b0, 3'b0};
  logic [2:0] m_st = '0;

  always @(posedge clk) begin
    logic [7:0] e_st;
    logic       pend, e_dat, e_oe, e_ovf;
    if (!rst_n) begin
      hq   = '{3'b0, 3'b0, 3'b0, 3'b0};
      m_st = '0;
    end else begin
      hq.push_front({raw_clk_err, raw_ovf, raw_udf});
      void'(hq.pop_back());
      for (int i = 0; i < 3; i++) begin
        logic s, p;
        s = hq[2][i];
        p = hq[3][i];
        if (mode_msb[i])                         m_st[i] = s;
        else if (mode_lsb[i] ? (p && !s) : (s && !p)) m_st[i] = 1'b1;
        else if (status_rd)                      m_st[i] = 1'b0;
      end
    end
    #1;
    e_st  = {4'b0, m_st[2], 1'b0, m_st[1], m_st[0]};
    pend  = |(m_st & src_en);
    e_dat = active_high ? pend : 1'b0;
    e_oe  = active_high ? 1'b1 : pend;
    e_ovf = hq[1][1] | hq[1][0];
    n_vec++;
    if (status_reg !== e_st || irq_out !== e_dat || irq_oe !== e_oe || ovf_pull_low !== e_ovf) begin
      n_bad++;
      $display("FAIL %s t=%0t: got st=%h irq=%b oe=%b ovf=%b, exp st=%h irq=%b oe=%b ovf=%b",
               ph, $time, status_reg, irq_out, irq_oe, ovf_pull_low, e_st, e_dat, e_oe, e_ovf);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string req);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s directed: got %h, exp %h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout, exp completion");
    finish_run();
  end

  initial begin
    // R10: reset state
    ph = "R10";
    raw_ovf = 1'b1;
    tick(4);
    chk(status_reg, 8'h00, "R10");
    chk({7'b0, irq_oe}, 8'h00, "R10");
    chk({7'b0, ovf_pull_low}, 8'h00, "R10");
    raw_ovf = 1'b0;
    rst_n = 1'b1;
    tick(4);

    // R2, R3: rising edge on overflow, masked
    ph = "R2";
    raw_ovf = 1'b1;
    tick(2);
    chk({7'b0, ovf_pull_low}, 8'h01, "R2");
    chk(status_reg, 8'h00, "R2");
    tick(1);
    chk(status_reg, 8'h02, "R2");
    ph = "R3";
    chk({7'b0, irq_oe}, 8'h00, "R3");
    tick(2);

    // R7: push-pull, enabled
    ph = "R7";
    src_en = 3'b010;
    active_high = 1'b1;
    tick(1);
    chk({6'b0, irq_out, irq_oe}, 8'h03, "R7");

    // R8: open-drain
    ph = "R8";
    active_high = 1'b0;
    tick(1);
    chk({6'b0, irq_out, irq_oe}, 8'h01, "R8");

    // R5: a read clears a latched edge while the condition stays high
    ph = "R5";
    status_rd = 1'b1;
    tick(1);
    status_rd = 1'b0;
    chk(status_reg, 8'h00, "R5");
    chk({6'b0, irq_out, irq_oe}, 8'h00, "R8");
    raw_ovf = 1'b0;
    tick(4);
    raw_ovf = 1'b1;
    tick(4);
    chk(status_reg, 8'h02, "R5");
    raw_ovf = 1'b0;
    tick(4);
    raw_ovf = 1'b1;
    tick(2);
    status_rd = 1'b1;      // read on the same edge as the new event
    tick(1);
    status_rd = 1'b0;
    chk(status_reg, 8'h02, "R5");
    status_rd = 1'b1;
    tick(1);
    status_rd = 1'b0;
    raw_ovf = 1'b0;
    tick(4);

    // R4, R9: falling edge on underflow, masked for the pin
    ph = "R4";
    src_en = 3'b000;
    mode_lsb = 3'b001;
    raw_udf = 1'b1;
    tick(4);
    chk(status_reg, 8'h00, "R4");
    ph = "R9";
    chk({7'b0, ovf_pull_low}, 8'h01, "R9");
    ph = "R4";
    raw_udf = 1'b0;
    tick(4);
    chk(status_reg, 8'h01, "R4");
    src_en = 3'b001;
    active_high = 1'b1;
    tick(1);
    chk({6'b0, irq_out, irq_oe}, 8'h03, "R4");
    status_rd = 1'b1;
    tick(1);
    status_rd = 1'b0;
    tick(2);

    // R6: level mode on clock error; a read has no effect
    ph = "R6";
    mode_msb = 3'b100;
    src_en = 3'b100;
    raw_clk_err = 1'b1;
    tick(4);
    chk(status_reg, 8'h08, "R6");
    status_rd = 1'b1;
    tick(2);
    status_rd = 1'b0;
    chk(status_reg, 8'h08, "R6");
    raw_clk_err = 1'b0;
    tick(4);
    chk(status_reg, 8'h00, "R6");
    mode_lsb = 3'b101;       // code 11 behaves as level
    raw_clk_err = 1'b1;
    tick(4);
    chk(status_reg, 8'h08, "R4");
    raw_clk_err = 1'b0;
    tick(4);

    // R1: all sources latched at once, reserved bits stay zero
    ph = "R1";
    mode_msb = 3'b000;
    mode_lsb = 3'b000;
    raw_clk_err = 1'b1; raw_ovf = 1'b1; raw_udf = 1'b1;
    tick(4);
    chk(status_reg, 8'h0B, "R1");
    raw_clk_err = 1'b0; raw_ovf = 1'b0; raw_udf = 1'b0;
    tick(4);
    finish_run();
  end

endmodule